// File: doc/BRIEF.md
# Infrared SIR pulse encoder and decoder

This block sits between the serial transmit and receive lines of a UART and an infrared optical transceiver. With infrared operation turned on, every bit cell in which the UART sends a zero is replaced by a short high pulse on the optical transmit line. Every pulse seen on the optical receive line is stretched back into a low level that lasts one whole bit period, which the UART can sample like ordinary serial data. With infrared operation off, both directions are plain wires.

An eight-bit control register sets the behaviour. Bit 7 turns infrared operation on. Bit 6 picks where the pulse width comes from. Bit 5 sets the receive polarity. The other bits always read back as zero. The pulse width is three-sixteenths of a bit. The bit can be measured either in 16x baud ticks or in periods of a fixed infrared clock, which is the peripheral clock divided by 2N+2 for a four-bit divider setting N. The UART also reports whether it is running in synchronous mode. Infrared operation is then refused and both directions stay plain wires.

Top module: `ir_sir_codec`

## Requirements
- R1: The control register reads 0x00 after reset. A write stores bits 7 (infrared enable), 6 (width source) and 5 (receive polarity). Bits 4..0 read as 0 whatever was written, so writing 0xFF reads back 0xE0.
- R2: Infrared operation is active only when control bit 7 is 1 and `sync_mode` is 0. Otherwise `ir_txd` equals `uart_txd` and `uart_rxd` equals `ir_rxd`.
- R3: While active, `ir_txd` idles low and is never high during a bit cell holding a 1. A bit cell starts whenever `uart_txd` changes, and again 16 ticks after the previous start. Each cell holding a 0, including back-to-back zero cells, produces exactly one high pulse that begins at the clock edge starting the cell.
- R4: With control bit 6 at 0, the pulse ends on the third `tick16` after its start. With ticks every T clocks, the pulse is high for 3T clocks.
- R5: With control bit 6 at 1, the pulse lasts three periods of a clock with period 2N+2 peripheral clocks, where N is `div_n`. That gives 6N+6 clocks whatever the tick rate.
- R6: With control bit 5 at 0, `ir_rxd` is inverted before edge detection. With bit 5 at 1, it is used as is.
- R7: While active, a rising edge of the polarity-adjusted receive input drives `uart_rxd` low until the sixteenth `tick16` after that edge. At all other times `uart_rxd` is high, and a short input pulse still gives the full low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| sync_mode | input | 1 | High when the UART runs in synchronous mode |
| div_n | input | 4 | Fixed infrared clock divider setting N |
| tick16 | input | 1 | One-clock enable at 16 times the baud rate |
| uart_txd | input | 1 | Serial transmit bit from the UART |
| ir_rxd | input | 1 | Receive line from the optical transceiver |
| ir_txd | output | 1 | Transmit line to the optical transceiver |
| uart_rxd | output | 1 | Recovered serial receive bit to the UART |

## Verification
The assertions assume that `uart_txd` changes only at bit boundaries set by `tick16`, that `tick16` is a single-clock strobe, and that the control register and `sync_mode` are steady while a pulse or a stretched low is in progress. The stimulus meets these assumptions. Each transmit bit is applied in the same clock as a tick and held for exactly sixteen ticks, and ticks come at a fixed spacing. The control register, `sync_mode` and `div_n` change only while the lines idle, and each change is followed by at least twenty ticks of settling time before anything is counted.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;

    // divider setting width and fixed-clock counter width (counts to 2N+1)
    localparam int unsigned DIV_W         = 4;
    localparam int unsigned FDIV_W        = DIV_W + 1;

    // bit period in 16x ticks and pulse length in width units
    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned PH_W          = $clog2(TICKS_PER_BIT);
    localparam int unsigned PULSE_UNITS   = 3;
    localparam int unsigned UNIT_W        = $clog2(PULSE_UNITS + 1);

    localparam int unsigned REG_W         = 8;
    localparam int unsigned RSVD_W        = REG_W - 3;

    typedef struct packed {
        logic ir_en;      // bit 7: infrared operation
        logic width_sel;  // bit 6: 1 = fixed clock sets width
        logic rx_keep;    // bit 5: 1 = receive data not inverted
    } ir_cfg_t;

endpackage

// File: rtl/ir_cfg_reg.sv
module ir_cfg_reg
    import ir_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ir_cfg_t          cfg,
    output logic [REG_W-1:0] rdata
);

    ir_cfg_t cfg_d, cfg_q;
    logic    unused_wbits;

    assign unused_wbits = ^wdata[RSVD_W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.ir_en     = wdata[REG_W-1];
            cfg_d.width_sel = wdata[REG_W-2];
            cfg_d.rx_keep   = wdata[REG_W-3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {cfg_q.ir_en, cfg_q.width_sel, cfg_q.rx_keep, {RSVD_W{1'b0}}};

endmodule

// File: rtl/ir_fix_div.sv
module ir_fix_div
    import ir_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_n,
    output logic             strobe
);

    logic [FDIV_W-1:0] cnt_d, cnt_q;
    logic [FDIV_W-1:0] limit;

    // one period is 2N+2 clocks: count 0 .. 2N+1
    assign limit  = {div_n, 1'b1};
    assign strobe = (cnt_q == limit);

    always_comb begin
        if (restart)     cnt_d = '0;
        else if (strobe) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ir_tx_mod.sv
module ir_tx_mod
    import ir_sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic txd,
    input  logic width_sel,
    input  logic fix_strobe,
    output logic restart,
    output logic pulse
);

    localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(PULSE_UNITS - 1);

    typedef struct packed {
        logic              txd;
        logic [PH_W-1:0]   ph;
        logic              pulse;
        logic [UNIT_W-1:0] units;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic   start;
    logic   adv;

    always_comb begin
        s_d     = s_q;
        start   = 1'b0;
        s_d.txd = txd;
        adv     = width_sel ? fix_strobe : tick;

        // bit cell tracking: a level change or a full cell of ticks opens a cell
        if (txd != s_q.txd) begin
            s_d.ph = '0;
            start  = !txd;
        end else if (tick) begin
            if (s_q.ph == LAST_PH) begin
                s_d.ph = '0;
                start  = !s_q.txd;
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end

        // pulse width in units of ticks or fixed-clock periods
        if (start) begin
            s_d.pulse = 1'b1;
            s_d.units = '0;
        end else if (s_q.pulse && adv) begin
            if (s_q.units == LAST_UNIT) begin
                s_d.pulse = 1'b0;
                s_d.units = '0;
            end else begin
                s_d.units = s_q.units + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{txd: 1'b1, ph: '0, pulse: 1'b0, units: '0};
        else        s_q <= s_d;
    end

    assign restart = start;
    assign pulse   = s_q.pulse;

endmodule

// File: rtl/ir_rx_demod.sv
module ir_rx_demod
    import ir_sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_pin,
    input  logic rx_keep,
    output logic rx_bit
);

    localparam logic [PH_W-1:0] LAST_CNT = PH_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic            lvl;
        logic            stretch;
        logic [PH_W-1:0] cnt;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic   pol;
    logic   rise;

    assign pol  = rx_keep ? rx_pin : ~rx_pin;
    assign rise = pol & ~s_q.lvl;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = pol;
        if (rise) begin
            s_d.stretch = 1'b1;
            s_d.cnt     = '0;
        end else if (s_q.stretch && tick) begin
            if (s_q.cnt == LAST_CNT) begin
                s_d.stretch = 1'b0;
                s_d.cnt     = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{lvl: 1'b1, stretch: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign rx_bit = ~s_q.stretch;

endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec
    import ir_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             sync_mode,
    input  logic [DIV_W-1:0] div_n,
    input  logic             tick16,
    input  logic             uart_txd,
    input  logic             ir_rxd,
    output logic             ir_txd,
    output logic             uart_rxd
);

    ir_cfg_t cfg;
    logic    ir_active;
    logic    div_restart;
    logic    div_strobe;
    logic    tx_pulse;
    logic    rx_bit;

    ir_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    ir_fix_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .div_n   (div_n),
        .strobe  (div_strobe)
    );

    ir_tx_mod u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .txd        (uart_txd),
        .width_sel  (cfg.width_sel),
        .fix_strobe (div_strobe),
        .restart    (div_restart),
        .pulse      (tx_pulse)
    );

    ir_rx_demod u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rx_pin  (ir_rxd),
        .rx_keep (cfg.rx_keep),
        .rx_bit  (rx_bit)
    );

    // infrared mode is refused while the UART is synchronous
    assign ir_active = cfg.ir_en & ~sync_mode;
    assign ir_txd    = ir_active ? tx_pulse : uart_txd;
    assign uart_rxd  = ir_active ? rx_bit   : ir_rxd;

endmodule

// File: rtl/ir_sir_codec_chk.sv
module ir_sir_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [2:0] wtop,
    input logic [7:0] cfg_rdata,
    input logic       sync_mode,
    input logic       tick16,
    input logic       uart_txd,
    input logic       ir_rxd,
    input logic       ir_txd,
    input logic       uart_rxd
);

    logic active;
    logic baud_w;

    assign active = cfg_rdata[7] & ~sync_mode;
    assign baud_w = active & ~cfg_rdata[6];

    // R1
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> cfg_rdata == {$past(wtop), 5'b00000});

    // R2
    sync_rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> uart_rxd == ir_rxd);

    // R3
    tx_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $rose(ir_txd)) |-> !$past(uart_txd));

    // R4
    tx_baud_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_w && $past(baud_w) && $fell(ir_txd)) |-> $past(tick16));

    // R7
    rx_stretch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $rose(uart_rxd)) |-> $past(tick16));

endmodule

bind ir_sir_codec ir_sir_codec_chk u_ir_sir_codec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .wtop      (cfg_wdata[7:5]),
    .cfg_rdata (cfg_rdata),
    .sync_mode (sync_mode),
    .tick16    (tick16),
    .uart_txd  (uart_txd),
    .ir_rxd    (ir_rxd),
    .ir_txd    (ir_txd),
    .uart_rxd  (uart_rxd)
);

// File: tb/ir_sir_codec_bench.sv
`timescale 1ns/1ps
module ir_sir_codec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       sync_mode = 1'b0;
    logic [3:0] div_n = 4'd0;
    logic       tick16 = 1'b0;
    logic       uart_txd = 1'b1;
    logic       ir_rxd = 1'b1;
    logic       ir_txd;
    logic       uart_rxd;

    always #2 clk = ~clk;

    ir_sir_codec u_ir_sir_codec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sync_mode (sync_mode),
        .div_n     (div_n),
        .tick16    (tick16),
        .uart_txd  (uart_txd),
        .ir_rxd    (ir_rxd),
        .ir_txd    (ir_txd),
        .uart_rxd  (uart_rxd)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        sync;
        logic [3:0]  div;
        logic [7:0]  per;
        logic [7:0]  data;
        logic [15:0] hi;
        logic [7:0]  rise;
    } vec_t;

    localparam int NV = 8;
    // expected: highs per zero cell = 3*per (baud) or 6N+6 (fixed); passthrough = ones*16*per
    localparam vec_t VECS [NV] = '{
        '{8'h80, 1'b0, 4'd0, 8'd4, 8'h55, 16'd60,  8'd5},
        '{8'h80, 1'b0, 4'd0, 8'd4, 8'h00, 16'd108, 8'd9},
        '{8'hC0, 1'b0, 4'd2, 8'd4, 8'h0F, 16'd90,  8'd5},
        '{8'hC0, 1'b0, 4'd2, 8'd8, 8'h0F, 16'd90,  8'd5},
        '{8'h80, 1'b0, 4'd0, 8'd8, 8'hFF, 16'd24,  8'd1},
        '{8'hC0, 1'b0, 4'd0, 8'd4, 8'hF0, 16'd30,  8'd5},
        '{8'h00, 1'b0, 4'd0, 8'd4, 8'hA5, 16'd320, 8'd4},
        '{8'h80, 1'b1, 4'd0, 8'd4, 8'hA5, 16'd320, 8'd4}
    };

    int   n_chk = 0;
    int   n_fail = 0;
    int   hi_acc = 0;
    int   lo_acc = 0;
    int   rise_acc = 0;
    logic prev_o = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic tk);
        tick16 = tk;
        @(negedge clk);
        if (ir_txd) hi_acc++;
        if (ir_txd && !prev_o) rise_acc++;
        prev_o = ir_txd;
        if (!uart_rxd) lo_acc++;
    endtask

    task automatic clear_acc();
        hi_acc   = 0;
        lo_acc   = 0;
        rise_acc = 0;
        prev_o   = ir_txd;
    endtask

    task automatic idle(input int nt, input int per);
        for (int t = 0; t < nt; t++)
            for (int c = 0; c < per; c++) step(c == 0);
        tick16 = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int per);
        for (int t = 0; t < 16; t++)
            for (int c = 0; c < per; c++) begin
                if (t == 0 && c == 0) uart_txd = b;
                step(c == 0);
            end
        tick16 = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wdata = v;
        cfg_wr    = 1'b1;
        tick16    = 1'b0;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // drives ir_rxd to lvl at the first cycle, back after plen cycles if plen > 0
    task automatic rx_window(input logic lvl, input int plen, input int per);
        clear_acc();
        for (int t = 0; t < 20; t++)
            for (int c = 0; c < per; c++) begin
                if (t == 0 && c == 0) ir_rxd = lvl;
                if (plen > 0 && t * per + c == plen) ir_rxd = ~lvl;
                step(c == 0);
            end
        tick16 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string req;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value, R2 passthrough at reset
        check(cfg_rdata == 8'h00, "R1 reset", int'(cfg_rdata), 0);
        check(ir_txd == 1'b1, "R2 reset tx pass", int'(ir_txd), 1);
        ir_rxd = 1'b0;
        @(negedge clk);
        check(uart_rxd == 1'b0, "R2 reset rx pass", int'(uart_rxd), 0);
        ir_rxd = 1'b1;

        // R1 reserved bits
        wr_cfg(8'hFF);
        check(cfg_rdata == 8'hE0, "R1 readback", int'(cfg_rdata), 224);

        // table of frames: start bit, 8 data bits LSB first, stop bit
        for (int i = 0; i < NV; i++) begin
            div_n     = VECS[i].div;
            sync_mode = VECS[i].sync;
            wr_cfg(VECS[i].ctrl);
            idle(20, int'(VECS[i].per));
            clear_acc();
            send_bit(1'b0, int'(VECS[i].per));
            for (int b = 0; b < 8; b++) send_bit(VECS[i].data[b], int'(VECS[i].per));
            send_bit(1'b1, int'(VECS[i].per));
            if (!VECS[i].ctrl[7] || VECS[i].sync) req = "R2";
            else if (VECS[i].ctrl[6])             req = "R5";
            else                                  req = "R4";
            check(hi_acc == int'(VECS[i].hi), req, hi_acc, int'(VECS[i].hi));
            check(rise_acc == int'(VECS[i].rise), "R3 pulse count", rise_acc, int'(VECS[i].rise));
            idle(20, int'(VECS[i].per));
        end

        // R3 idle line gives no pulse
        sync_mode = 1'b0;
        wr_cfg(8'h80);
        idle(20, 4);
        clear_acc();
        idle(20, 4);
        check(hi_acc == 0, "R3 idle", hi_acc, 0);

        // R6 inverted polarity: falling line is a rising edge
        rx_window(1'b0, 0, 4);
        check(lo_acc == 64, "R6 inverted", lo_acc, 64);
        ir_rxd = 1'b1;
        idle(20, 4);

        // R7 short pulse stretched to a full bit
        rx_window(1'b0, 3, 4);
        check(lo_acc == 64, "R7 stretch", lo_acc, 64);

        // R6 non-inverted polarity
        wr_cfg(8'hA0);
        idle(20, 4);
        rx_window(1'b0, 0, 4);
        check(lo_acc == 0, "R6 keep fall", lo_acc, 0);
        rx_window(1'b1, 0, 4);
        check(lo_acc == 64, "R6 keep rise", lo_acc, 64);
        check(uart_rxd == 1'b1, "R7 idle high", int'(uart_rxd), 1);

        // R2 synchronous mode refuses infrared operation
        wr_cfg(8'h80);
        sync_mode = 1'b1;
        ir_rxd    = 1'b0;
        @(negedge clk);
        check(uart_rxd == 1'b0, "R2 sync rx", int'(uart_rxd), 0);
        ir_rxd   = 1'b1;
        uart_txd = 1'b0;
        @(negedge clk);
        check(ir_txd == 1'b0, "R2 sync tx low", int'(ir_txd), 0);
        uart_txd = 1'b1;
        @(negedge clk);
        check(ir_txd == 1'b1, "R2 sync tx high", int'(ir_txd), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule